// File: doc/BRIEF.md
# Host-target mailbox console

A memory-mapped mailbox through which a 32-bit processor talks to its host. It holds two 64-bit registers, a request register (target to host) and a response register (host to target). The processor reaches each register as two 32-bit halves. The processor writes a request in two steps: the low half first, then the high half. The second write commits the request. The block splits the committed word into a device number, a command and a payload, and then acts on it.

Three requests do real work. One reports a test exit code as a single-cycle pulse. One sends a console character out through a valid/ready byte stream. One arms a pending console read. A character that arrives on the input byte stream is posted into the response register, tagged with the upper 16 bits of the pending read. Every other request is answered with a zero response value. The request register returns to zero once a request is consumed. A nonzero request register blocks any new request from starting.

Top module: `hostlink_mailbox`

## Requirements
- R1: After reset the request register, the response register, the pending-read tag and the internal accept flag are zero. Every readable address returns 0, and tx_valid and exit_valid are low.
- R2: With the default offsets, the request register is read at byte addresses 0x00 (bits 31:0) and 0x04 (bits 63:32), and the response register at 0x08 (bits 31:0) and 0x0C (bits 63:32). Reads are combinational on bus_addr. Any other address reads 0.
- R3: A write to address 0x00 is taken only while the whole request register is zero. It loads bits 31:0, clears bits 63:32 and sets the accept flag. A write to 0x00 while the register is nonzero changes nothing in the register and clears the accept flag.
- R4: A write to 0x04 ORs the data into request bits 63:32 only while the accept flag is set. That write commits the request and clears the flag. Without the flag the write has no effect.
- R5: The committed word carries the device in bits 63:56, the command in bits 55:48 and the payload in bits 47:0. Device 0, command 0 with payload bit 0 set raises exit_valid for exactly one cycle, in the cycle after the commit. exit_code is payload bits 8:1. The response becomes {request bits 63:48, 48'h0}, and the request register clears.
- R6: Device 0, command 0 with payload bit 0 clear produces no exit pulse. It is answered like any unknown request (R10).
- R7: Device 1, command 1 drives tx_valid with tx_data set to payload bits 7:0 from the cycle after the commit. In the cycle after tx_valid and tx_ready are both high, tx_valid drops, the response becomes {request bits 63:48, 32'h0, 16'h0100 | byte} and the request register clears.
- R8: While tx_valid is high and tx_ready is low, tx_data holds steady and the request register stays nonzero, so writes to 0x00 are refused.
- R9: Device 1, command 0 stores request bits 63:48 as the pending-read tag and clears the request register. It leaves the response register unchanged.
- R10: Any other device or command sets the response to {request bits 63:48, 48'h0} and clears the request register.
- R11: rx_valid is always accepted. In the next cycle the response becomes {pending tag, 32'h0, 16'h0100 | rx_data}, overwriting any unread earlier character.
- R12: A write to 0x08 loads the response with the data zero-extended to 64 bits. A write to 0x0C ORs the data into response bits 63:32.
- R13: When several sources update the response in one cycle, a request completion (R5, R6, R7, R10) wins over an arriving character, and an arriving character wins over a processor write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_we | input | 1 | Write strobe for one 32-bit half |
| bus_addr | input | 6 | Byte address of the half |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr |
| tx_valid | output | 1 | Console byte offered |
| tx_data | output | 8 | Console byte |
| tx_ready | input | 1 | Sink takes the console byte |
| rx_valid | input | 1 | Input character present (always taken) |
| rx_data | input | 8 | Input character |
| exit_valid | output | 1 | One-cycle exit report |
| exit_code | output | 8 | Exit code, held after the pulse |

## Verification
The bench targets the write lock: a second low write while a request is outstanding, followed by a high write with no accept flag. A design that let either write through would corrupt the queued word or fire a phantom command. It stalls the console sink for several cycles and checks that the byte and the lock hold. A design that completes early loses characters or unlocks the register too soon. It aims same-cycle collisions on the response register (completion against an arriving character, and an arriving character against a processor write) and repeated characters with no read in between. A wrong priority shows up as a stale or untagged response. It also checks exit-code truncation and the even-payload case that must stay silent.

// File: rtl/hostlink_pkg.sv
package hostlink_pkg;
   localparam int unsigned RESP_W = 16;

   typedef enum logic [2:0] {
      ACT_EXIT,
      ACT_SYSCALL,
      ACT_PUTC,
      ACT_GETC,
      ACT_UNKNOWN
   } act_e;
endpackage

// File: rtl/hl_decode.sv
module hl_decode
   import hostlink_pkg::*;
#(
   parameter int unsigned DEV_W  = 8,
   parameter int unsigned CMD_W  = 8,
   parameter int unsigned CODE_W = 8,
   parameter int unsigned CHAR_W = 8,
   parameter int unsigned LOW_W  = 9
)(
   input  logic [DEV_W-1:0]  dev,
   input  logic [CMD_W-1:0]  cmd,
   input  logic [LOW_W-1:0]  pay_lo,
   output act_e              act,
   output logic [CODE_W-1:0] code,
   output logic [CHAR_W-1:0] ch
);
   localparam logic [DEV_W-1:0] DEV_SYS  = DEV_W'(0);
   localparam logic [DEV_W-1:0] DEV_CONS = DEV_W'(1);
   localparam logic [CMD_W-1:0] CMD_ZERO = CMD_W'(0);
   localparam logic [CMD_W-1:0] CMD_ONE  = CMD_W'(1);

   assign code = pay_lo[CODE_W:1];
   assign ch   = pay_lo[CHAR_W-1:0];

   always_comb begin
      if (dev == DEV_SYS && cmd == CMD_ZERO)
         act = pay_lo[0] ? ACT_EXIT : ACT_SYSCALL;
      else if (dev == DEV_CONS && cmd == CMD_ONE)
         act = ACT_PUTC;
      else if (dev == DEV_CONS && cmd == CMD_ZERO)
         act = ACT_GETC;
      else
         act = ACT_UNKNOWN;
   end
endmodule

// File: rtl/hl_txport.sv
module hl_txport #(
   parameter int unsigned DATA_W = 8
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [DATA_W-1:0] load_data,
   input  logic              tx_ready,
   output logic              tx_valid,
   output logic [DATA_W-1:0] tx_data,
   output logic              done
);
   assign done = tx_valid & tx_ready;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tx_valid <= 1'b0;
         tx_data  <= '0;
      end else if (load) begin
         tx_valid <= 1'b1;
         tx_data  <= load_data;
      end else if (done) begin
         tx_valid <= 1'b0;
      end
   end
endmodule

// File: rtl/hostlink_mailbox.sv
module hostlink_mailbox
   import hostlink_pkg::*;
#(
   parameter int unsigned HALF_W    = 32,
   parameter int unsigned ADDR_W    = 6,
   parameter int unsigned REQ_OFS   = 0,
   parameter int unsigned RSP_OFS   = 8,
   parameter int unsigned DEV_W     = 8,
   parameter int unsigned CMD_W     = 8,
   parameter int unsigned CHAR_W    = 8,
   parameter int unsigned CODE_W    = 8,
   parameter bit          READ_PIPE = 1'b0
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_we,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [HALF_W-1:0] bus_wdata,
   output logic [HALF_W-1:0] bus_rdata,
   output logic              tx_valid,
   output logic [CHAR_W-1:0] tx_data,
   input  logic              tx_ready,
   input  logic              rx_valid,
   input  logic [CHAR_W-1:0] rx_data,
   output logic              exit_valid,
   output logic [CODE_W-1:0] exit_code
);
   localparam int unsigned WORD_W = 2 * HALF_W;
   localparam int unsigned TAG_W  = DEV_W + CMD_W;
   localparam int unsigned MID_W  = WORD_W - TAG_W - RESP_W;
   localparam int unsigned LOW_W  = (CODE_W + 1 > CHAR_W) ? CODE_W + 1 : CHAR_W;
   localparam logic [ADDR_W-1:0] A_REQ_LO = ADDR_W'(REQ_OFS);
   localparam logic [ADDR_W-1:0] A_REQ_HI = ADDR_W'(REQ_OFS + 4);
   localparam logic [ADDR_W-1:0] A_RSP_LO = ADDR_W'(RSP_OFS);
   localparam logic [ADDR_W-1:0] A_RSP_HI = ADDR_W'(RSP_OFS + 4);
   localparam logic [RESP_W-1:0] CHAR_TAG = RESP_W'(1) << CHAR_W;

   // elaboration-time parameter checks
   if (REQ_OFS % 8 != 0 || RSP_OFS % 8 != 0) begin : g_bad_align
      $error("register offsets must be 8-byte aligned");
   end
   if (REQ_OFS == RSP_OFS) begin : g_bad_overlap
      $error("register offsets must differ");
   end
   if ((REQ_OFS + 8 > (1 << ADDR_W)) || (RSP_OFS + 8 > (1 << ADDR_W))) begin : g_bad_range
      $error("register offsets exceed the address width");
   end
   if (MID_W < 1 || CHAR_W >= RESP_W) begin : g_bad_fields
      $error("field widths do not fit the 64-bit word");
   end
   if (LOW_W > WORD_W - TAG_W) begin : g_bad_payload
      $error("exit code does not fit in the payload");
   end

   function automatic logic [WORD_W-1:0] mk_resp(input logic [TAG_W-1:0] tag,
                                                 input logic [RESP_W-1:0] val);
      return {tag, {MID_W{1'b0}}, val};
   endfunction

   logic [WORD_W-1:0] req_q, rsp_q, full_word;
   logic [TAG_W-1:0]  pend_tag_q;
   logic              allow_q;
   logic              wr_req_lo, wr_req_hi, wr_rsp_lo, wr_rsp_hi, commit;
   logic              tx_load, tx_done;
   act_e              dec_act;
   logic [CODE_W-1:0] dec_code;
   logic [CHAR_W-1:0] dec_ch;
   logic [HALF_W-1:0] rd_mux;

   assign wr_req_lo = bus_we && bus_addr == A_REQ_LO;
   assign wr_req_hi = bus_we && bus_addr == A_REQ_HI;
   assign wr_rsp_lo = bus_we && bus_addr == A_RSP_LO;
   assign wr_rsp_hi = bus_we && bus_addr == A_RSP_HI;
   assign commit    = wr_req_hi && allow_q;
   assign full_word = {req_q[WORD_W-1:HALF_W] | bus_wdata, req_q[HALF_W-1:0]};
   assign tx_load   = commit && dec_act == ACT_PUTC;

   hl_decode #(
      .DEV_W(DEV_W), .CMD_W(CMD_W), .CODE_W(CODE_W), .CHAR_W(CHAR_W), .LOW_W(LOW_W)
   ) u_dec (
      .dev    (full_word[WORD_W-1 -: DEV_W]),
      .cmd    (full_word[WORD_W-DEV_W-1 -: CMD_W]),
      .pay_lo (full_word[LOW_W-1:0]),
      .act    (dec_act),
      .code   (dec_code),
      .ch     (dec_ch)
   );

   hl_txport #(.DATA_W(CHAR_W)) u_tx (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (tx_load),
      .load_data (dec_ch),
      .tx_ready  (tx_ready),
      .tx_valid  (tx_valid),
      .tx_data   (tx_data),
      .done      (tx_done)
   );

   // later statements take priority: completion > rx > processor write
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         req_q      <= '0;
         rsp_q      <= '0;
         pend_tag_q <= '0;
         allow_q    <= 1'b0;
         exit_valid <= 1'b0;
         exit_code  <= '0;
      end else begin
         exit_valid <= 1'b0;
         if (wr_rsp_lo)
            rsp_q <= {{HALF_W{1'b0}}, bus_wdata};
         else if (wr_rsp_hi)
            rsp_q[WORD_W-1:HALF_W] <= rsp_q[WORD_W-1:HALF_W] | bus_wdata;
         if (rx_valid)
            rsp_q <= mk_resp(pend_tag_q, CHAR_TAG | RESP_W'(rx_data));
         if (wr_req_lo) begin
            if (req_q == '0) begin
               req_q   <= {{HALF_W{1'b0}}, bus_wdata};
               allow_q <= 1'b1;
            end else begin
               allow_q <= 1'b0;
            end
         end
         if (commit) begin
            allow_q <= 1'b0;
            case (dec_act)
               ACT_GETC: begin
                  pend_tag_q <= full_word[WORD_W-1 -: TAG_W];
                  req_q      <= '0;
               end
               ACT_PUTC: req_q <= full_word;
               default: begin
                  if (dec_act == ACT_EXIT) begin
                     exit_valid <= 1'b1;
                     exit_code  <= dec_code;
                  end
                  rsp_q <= mk_resp(full_word[WORD_W-1 -: TAG_W], '0);
                  req_q <= '0;
               end
            endcase
         end
         if (tx_done) begin
            rsp_q <= mk_resp(req_q[WORD_W-1 -: TAG_W], CHAR_TAG | RESP_W'(tx_data));
            req_q <= '0;
         end
      end
   end

   always_comb begin
      if (bus_addr == A_REQ_LO)      rd_mux = req_q[HALF_W-1:0];
      else if (bus_addr == A_REQ_HI) rd_mux = req_q[WORD_W-1:HALF_W];
      else if (bus_addr == A_RSP_LO) rd_mux = rsp_q[HALF_W-1:0];
      else if (bus_addr == A_RSP_HI) rd_mux = rsp_q[WORD_W-1:HALF_W];
      else                           rd_mux = '0;
   end

   if (READ_PIPE) begin : g_rd_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) bus_rdata <= '0;
         else        bus_rdata <= rd_mux;
      end
   end else begin : g_rd_comb
      assign bus_rdata = rd_mux;
   end
endmodule

// File: rtl/hl_checker.sv
module hl_checker #(
   parameter int unsigned ADDR_W  = 6,
   parameter int unsigned WORD_W  = 64,
   parameter int unsigned REQ_OFS = 0,
   parameter int unsigned CHAR_W  = 8
)(
   input logic              clk,
   input logic              rst_n,
   input logic              bus_we,
   input logic [ADDR_W-1:0] bus_addr,
   input logic              tx_valid,
   input logic              tx_ready,
   input logic [CHAR_W-1:0] tx_data,
   input logic              rx_valid,
   input logic [CHAR_W-1:0] rx_data,
   input logic              exit_valid,
   input logic [WORD_W-1:0] req_q,
   input logic [CHAR_W:0]   rsp_lo,
   input logic              allow_q
);
   logic lo_wr, hi_commit, handshake;
   assign lo_wr     = bus_we && bus_addr == ADDR_W'(REQ_OFS);
   assign hi_commit = bus_we && bus_addr == ADDR_W'(REQ_OFS + 4) && allow_q;
   assign handshake = tx_valid && tx_ready;

   AST_TX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      tx_valid && !tx_ready |=> tx_valid && $stable(tx_data)); // R8
   AST_TX_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      tx_valid |-> req_q != '0); // R8
   AST_EXIT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      exit_valid |=> !exit_valid); // R5
   AST_REQ_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
      lo_wr && req_q != '0 && !handshake |=> !allow_q && $stable(req_q)); // R3
   AST_ALLOW_DROP: assert property (@(posedge clk) disable iff (!rst_n)
      hi_commit |=> !allow_q); // R4
   AST_RX_POST: assert property (@(posedge clk) disable iff (!rst_n)
      rx_valid && !handshake && !hi_commit |=> rsp_lo == {1'b1, $past(rx_data)}); // R11
endmodule

bind hostlink_mailbox hl_checker #(
   .ADDR_W(ADDR_W), .WORD_W(WORD_W), .REQ_OFS(REQ_OFS), .CHAR_W(CHAR_W)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .bus_we     (bus_we),
   .bus_addr   (bus_addr),
   .tx_valid   (tx_valid),
   .tx_ready   (tx_ready),
   .tx_data    (tx_data),
   .rx_valid   (rx_valid),
   .rx_data    (rx_data),
   .exit_valid (exit_valid),
   .req_q      (req_q),
   .rsp_lo     (rsp_q[CHAR_W:0]),
   .allow_q    (allow_q)
);

// File: tb/tb_hostlink_mailbox.sv
module tb_hostlink_mailbox;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_we = 1'b0;
   logic [5:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        tx_valid, tx_ready = 1'b1;
   logic [7:0]  tx_data;
   logic        rx_valid = 1'b0;
   logic [7:0]  rx_data = '0;
   logic        exit_valid;
   logic [7:0]  exit_code;

   int checks = 0, errors = 0, n_exit = 0;
   logic [7:0] last_code = '0;
   string phase = "R1";

   always #10 clk = ~clk;

   hostlink_mailbox dut (
      .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tx_valid(tx_valid),
      .tx_data(tx_data), .tx_ready(tx_ready), .rx_valid(rx_valid),
      .rx_data(rx_data), .exit_valid(exit_valid), .exit_code(exit_code)
   );

   // behavioural reference model
   logic [63:0] m_req, m_rsp, full, o_req;
   logic [15:0] m_pend;
   logic        m_allow, m_txv, m_exv, o_txv, o_allow;
   logic [7:0]  m_txd, m_exc, o_txd;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_req = '0; m_rsp = '0; m_pend = '0; m_allow = 0;
         m_txv = 0; m_txd = '0; m_exv = 0; m_exc = '0;
      end else begin
         o_req = m_req; o_txv = m_txv; o_txd = m_txd; o_allow = m_allow;
         m_exv = 0;
         if (bus_we && bus_addr == 8) m_rsp = {32'h0, bus_wdata};
         else if (bus_we && bus_addr == 12) m_rsp[63:32] = m_rsp[63:32] | bus_wdata;
         if (rx_valid) m_rsp = {m_pend, 32'h0, 8'h01, rx_data};
         if (bus_we && bus_addr == 0) begin
            if (o_req == 0) begin m_req = {32'h0, bus_wdata}; m_allow = 1; end
            else m_allow = 0;
         end
         if (bus_we && bus_addr == 4 && o_allow) begin
            full = {o_req[63:32] | bus_wdata, o_req[31:0]};
            m_allow = 0;
            if (full[63:56] == 1 && full[55:48] == 0) begin
               m_pend = full[63:48]; m_req = '0;
            end else if (full[63:56] == 1 && full[55:48] == 1) begin
               m_req = full; m_txv = 1; m_txd = full[7:0];
            end else begin
               if (full[63:48] == 0 && full[0]) begin m_exv = 1; m_exc = full[8:1]; end
               m_rsp = {full[63:48], 48'h0}; m_req = '0;
            end
         end
         if (o_txv && tx_ready) begin
            m_rsp = {o_req[63:48], 32'h0, 8'h01, o_txd}; m_req = '0; m_txv = 0;
         end
      end
   end

   function automatic logic [31:0] m_read(input logic [5:0] a);
      case (a)
         6'd0:  return m_req[31:0];
         6'd4:  return m_req[63:32];
         6'd8:  return m_rsp[31:0];
         6'd12: return m_rsp[63:32];
         default: return 32'h0;
      endcase
   endfunction

   task automatic chk(input string tag, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
      end
   endtask

   // per-cycle comparison, away from the clock edge
   always begin
      @(posedge clk);
      #5;
      if (rst_n) begin
         chk(phase, "tx_valid", 64'(tx_valid), 64'(m_txv));
         if (m_txv) chk(phase, "tx_data", 64'(tx_data), 64'(m_txd));
         chk(phase, "exit_valid", 64'(exit_valid), 64'(m_exv));
         chk(phase, "exit_code", 64'(exit_code), 64'(m_exc));
         chk(phase, "bus_rdata", 64'(bus_rdata), 64'(m_read(bus_addr)));
         if (exit_valid) begin n_exit++; last_code = exit_code; end
      end
   end

   task automatic wr(input logic [5:0] a, input logic [31:0] d);
      @(negedge clk); bus_we = 1; bus_addr = a; bus_wdata = d;
      @(negedge clk); bus_we = 0;
   endtask

   task automatic rd_check(input string tag, input logic [5:0] a, input logic [31:0] exp);
      @(negedge clk); bus_addr = a;
      #1 chk(tag, "read", 64'(bus_rdata), 64'(exp));
   endtask

   task automatic rx_send(input logic [7:0] c);
      @(negedge clk); rx_valid = 1; rx_data = c;
      @(negedge clk); rx_valid = 0;
   endtask

   task automatic do_reset();
      @(negedge clk); rst_n = 0;
      repeat (2) @(negedge clk);
      rst_n = 1;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      int ex0;
      repeat (2) @(negedge clk);
      rst_n = 1;
      // R1 and R2: reset state and unmapped address
      phase = "R1";
      rd_check("R1", 0, 0); rd_check("R1", 4, 0); rd_check("R1", 8, 0); rd_check("R1", 12, 0);
      rd_check("R2", 16, 0);
      chk("R1", "tx_valid", 64'(tx_valid), 0);
      // R3/R4: lock and gated high write
      phase = "R3";
      wr(0, 32'h12345678);
      rd_check("R2", 0, 32'h12345678); rd_check("R2", 4, 0);
      wr(0, 32'h0000DEAD);
      rd_check("R3", 0, 32'h12345678);
      phase = "R4";
      wr(4, 32'hFFFF0000);
      rd_check("R4", 4, 0);
      do_reset();
      // R7: console output, sink ready
      phase = "R7";
      wr(0, 32'h41); wr(4, 32'h01010000);
      @(negedge clk);
      rd_check("R7", 8, 32'h141); rd_check("R7", 12, 32'h01010000); rd_check("R7", 0, 0);
      // R8: stalled sink
      phase = "R8";
      tx_ready = 0;
      wr(0, 32'h5A); wr(4, 32'h01010000);
      chk("R8", "tx_valid", 64'(tx_valid), 1); chk("R8", "tx_data", 64'(tx_data), 64'h5A);
      wr(0, 32'h77);
      rd_check("R8", 0, 32'h5A);
      repeat (3) @(negedge clk);
      chk("R8", "tx_data held", 64'(tx_data), 64'h5A);
      tx_ready = 1;
      @(negedge clk); @(negedge clk);
      chk("R8", "tx_valid drop", 64'(tx_valid), 0);
      rd_check("R8", 8, 32'h15A);
      // R5: exit reports
      phase = "R5";
      ex0 = n_exit;
      wr(0, 32'h55); wr(4, 32'h0);
      @(negedge clk);
      chk("R5", "exit count", 64'(n_exit - ex0), 1); chk("R5", "exit code", 64'(last_code), 64'h2A);
      rd_check("R5", 8, 0); rd_check("R5", 0, 0);
      wr(0, 32'hFFFFFE03); wr(4, 32'h0);
      @(negedge clk);
      chk("R5", "truncated code", 64'(last_code), 64'h01);
      // R6: even payload, no exit
      phase = "R6";
      wr(8, 32'hAAAA);
      ex0 = n_exit;
      wr(0, 32'h10); wr(4, 32'h00001234);
      @(negedge clk);
      chk("R6", "no exit", 64'(n_exit - ex0), 0);
      rd_check("R6", 8, 0);
      // R10: unknown device and command
      phase = "R10";
      wr(0, 32'h99); wr(4, 32'h05CC0000);
      rd_check("R10", 12, 32'h05CC0000); rd_check("R10", 8, 0); rd_check("R10", 0, 0);
      wr(0, 32'h1); wr(4, 32'h01070000);
      rd_check("R10", 12, 32'h01070000);
      // R9: pending read
      phase = "R9";
      wr(8, 32'h3333);
      wr(0, 32'h1); wr(4, 32'h0100BEEF);
      rd_check("R9", 8, 32'h3333); rd_check("R9", 0, 0); rd_check("R9", 4, 0);
      // R11: input characters overwrite
      phase = "R11";
      rx_send(8'h78);
      rd_check("R11", 8, 32'h178); rd_check("R11", 12, 32'h01000000);
      rx_send(8'h79);
      rd_check("R11", 8, 32'h179);
      // R12: processor writes to the response
      phase = "R12";
      wr(8, 32'hCAFE0001);
      rd_check("R12", 12, 0); rd_check("R12", 8, 32'hCAFE0001);
      wr(12, 32'h00F0); wr(12, 32'h0F00);
      rd_check("R12", 12, 32'h0FF0);
      // R13: collisions on the response
      phase = "R13";
      @(negedge clk); bus_we = 1; bus_addr = 8; bus_wdata = 32'h1111; rx_valid = 1; rx_data = 8'h30;
      @(negedge clk); bus_we = 0; rx_valid = 0;
      rd_check("R13", 8, 32'h130);
      tx_ready = 0;
      wr(0, 32'h33); wr(4, 32'h01010000);
      @(negedge clk); tx_ready = 1; rx_valid = 1; rx_data = 8'h44;
      @(negedge clk); rx_valid = 0;
      rd_check("R13", 8, 32'h133); rd_check("R13", 12, 32'h01010000);
      repeat (3) @(negedge clk);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule